// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block is the data half of a small accumulator machine: an arithmetic and logic unit fused to a single accumulator register, plus two condition flags that describe whatever the accumulator currently holds. Each operation has a fixed operand source. Addition, bitwise AND and bitwise OR combine the accumulator with the data bus, complement works on the accumulator alone, and load copies the bus straight through. Whatever the operation produces is written back into the accumulator.

A sequencer outside this block drives the operation code and the data bus, then raises the write enable for the one cycle in which the result should be captured. The negative and zero flags are taken from the accumulator register, not from the raw result, so they change only when the accumulator changes and a later conditional branch sees a stable value. There is no carry or overflow output: addition wraps around modulo 2^WIDTH.

Top module: `acc_alu`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the accumulator to zero, whatever acc_we and op_sel are. After that edge zero_flag is 1 and neg_flag is 0.
- R2: When acc_we is low at a rising edge and rst is low, the accumulator and both flags keep their values, whatever op_sel and bus_in are.
- R3: With op_sel = 3'b000 (add) and acc_we high, the accumulator takes (acc + bus_in) mod 256. The carry out is dropped.
- R4: With op_sel = 3'b001 (and) and acc_we high, the accumulator takes acc & bus_in.
- R5: With op_sel = 3'b010 (or) and acc_we high, the accumulator takes acc | bus_in.
- R6: With op_sel = 3'b011 (complement) and acc_we high, the accumulator takes ~acc. The value on bus_in has no effect on the result.
- R7: With op_sel = 3'b100 (load) and acc_we high, the accumulator takes bus_in unchanged. The previous accumulator value has no effect on the result.
- R8: neg_flag always equals the most significant bit (bit 7) of the accumulator output acc_q.
- R9: zero_flag is 1 exactly when all bits of acc_q are 0.
- R10: The codes 3'b101, 3'b110 and 3'b111 are not operations. With acc_we high they leave the accumulator and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, takes priority over acc_we |
| op_sel | input | 3 | Operation code: 000 add, 001 and, 010 or, 011 complement, 100 load |
| bus_in | input | 8 | Data bus operand |
| acc_we | input | 1 | Accumulator write enable for this cycle |
| acc_q | output | 8 | Accumulator contents |
| neg_flag | output | 1 | Sign bit of the accumulator |
| zero_flag | output | 1 | High when the accumulator is all zeros |

## Verification
The bound checker tests a number of rules on every clock. The reset clear, hold without write enable, and hold on reserved codes are all checked. Each of the five operations is checked against the previous accumulator and bus values, and both flags are checked against the accumulator bits. Those properties cannot show a few things that only the bench's scenarios can. The first is that additions wrap correctly at the 255 boundary and clear to zero when two values of 0x80 are added. The second is that complement and load really ignore their unused operand when that operand holds an extreme pattern. The third is that long random sequences interleave writes, holds, reserved codes and mid-run resets with no drift between the accumulator and the behavioural model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   localparam int OP_W = 3;

   localparam logic [OP_W-1:0] OP_ADD  = 3'b000;
   localparam logic [OP_W-1:0] OP_AND  = 3'b001;
   localparam logic [OP_W-1:0] OP_OR   = 3'b010;
   localparam logic [OP_W-1:0] OP_NOT  = 3'b011;
   localparam logic [OP_W-1:0] OP_LOAD = 3'b100;

   // adder implementation choices
   localparam int ADDER_BEHAV  = 0;
   localparam int ADDER_RIPPLE = 1;

   function automatic logic op_is_legal(input logic [OP_W-1:0] code);
      return code <= OP_LOAD;
   endfunction
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int WIDTH = 8,
   parameter int STYLE = acc_alu_pkg::ADDER_BEHAV
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum
);
   generate
      if (STYLE == acc_alu_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
         end
      end else if (STYLE == acc_alu_pkg::ADDER_BEHAV) begin : g_behav
         // carry out is not kept: wrap modulo 2^WIDTH
         assign sum = a + b;
      end else begin : g_bad_style
         $error("acc_alu_adder: unknown STYLE %0d", STYLE);
      end
   endgenerate
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core #(
   parameter int WIDTH = 8,
   parameter int ADDER_STYLE = acc_alu_pkg::ADDER_BEHAV
) (
   input  logic [acc_alu_pkg::OP_W-1:0] op,
   input  logic [WIDTH-1:0]             acc_val,
   input  logic [WIDTH-1:0]             bus_val,
   output logic [WIDTH-1:0]             result,
   output logic                         legal
);
   import acc_alu_pkg::*;

   logic [WIDTH-1:0] add_res;

   acc_alu_adder #(
      .WIDTH (WIDTH),
      .STYLE (ADDER_STYLE)
   ) u_adder (
      .a   (acc_val),
      .b   (bus_val),
      .sum (add_res)
   );

   assign legal = op_is_legal(op);

   always_comb begin
      unique case (op)
         OP_ADD:  result = add_res;
         OP_AND:  result = acc_val & bus_val;
         OP_OR:   result = acc_val | bus_val;
         OP_NOT:  result = ~acc_val;
         OP_LOAD: result = bus_val;
         default: result = acc_val;
      endcase
   end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] acc_val,
   output logic             neg,
   output logic             zero
);
   localparam int SIGN_BIT = WIDTH - 1;

   assign neg  = acc_val[SIGN_BIT];
   assign zero = ~|acc_val;
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = acc_alu_pkg::ADDER_RIPPLE
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [acc_alu_pkg::OP_W-1:0] op_sel,
   input  logic [WIDTH-1:0]             bus_in,
   input  logic                         acc_we,
   output logic [WIDTH-1:0]             acc_q,
   output logic                         neg_flag,
   output logic                         zero_flag
);
   localparam logic [WIDTH-1:0] ACC_CLEAR = '0;

   generate
      if (WIDTH < 2) begin : g_width_chk
         $error("acc_alu: WIDTH must be at least 2, got %0d", WIDTH);
      end
   endgenerate

   logic [WIDTH-1:0] acc_r;
   logic [WIDTH-1:0] alu_res;
   logic             op_legal;
   logic             commit;

   acc_alu_core #(
      .WIDTH       (WIDTH),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_core (
      .op      (op_sel),
      .acc_val (acc_r),
      .bus_val (bus_in),
      .result  (alu_res),
      .legal   (op_legal)
   );

   assign commit = acc_we & op_legal;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_r <= ACC_CLEAR;
      end else if (commit) begin
         acc_r <= alu_res;
      end
   end

   acc_alu_flags #(
      .WIDTH (WIDTH)
   ) u_flags (
      .acc_val (acc_r),
      .neg     (neg_flag),
      .zero    (zero_flag)
   );

   assign acc_q = acc_r;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [2:0]       op_sel,
   input logic [WIDTH-1:0] bus_in,
   input logic             acc_we,
   input logic [WIDTH-1:0] acc_q,
   input logic             neg_flag,
   input logic             zero_flag
);
   logic live;
   assign live = !rst && acc_we;

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (acc_q == '0 && zero_flag && !neg_flag));

   assert_hold_no_we_R2: assert property (@(posedge clk) disable iff (rst)
      !acc_we |=> $stable(acc_q));

   assert_add_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (live && op_sel == 3'b000) |=> acc_q == WIDTH'($past(acc_q) + $past(bus_in)));

   assert_and_R4: assert property (@(posedge clk) disable iff (rst)
      (live && op_sel == 3'b001) |=> acc_q == ($past(acc_q) & $past(bus_in)));

   assert_or_R5: assert property (@(posedge clk) disable iff (rst)
      (live && op_sel == 3'b010) |=> acc_q == ($past(acc_q) | $past(bus_in)));

   assert_not_R6: assert property (@(posedge clk) disable iff (rst)
      (live && op_sel == 3'b011) |=> acc_q == ~$past(acc_q));

   assert_load_R7: assert property (@(posedge clk) disable iff (rst)
      (live && op_sel == 3'b100) |=> acc_q == $past(bus_in));

   assert_neg_sign_R8: assert property (@(posedge clk) disable iff (rst)
      neg_flag == acc_q[WIDTH-1]);

   assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
      zero_flag == (acc_q == '0));

   assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (live && op_sel > 3'b100) |=> ($stable(acc_q) && $stable(zero_flag) && $stable(neg_flag)));
endmodule

bind acc_alu acc_alu_checker #(.WIDTH(WIDTH)) u_acc_alu_checker (
   .clk       (clk),
   .rst       (rst),
   .op_sel    (op_sel),
   .bus_in    (bus_in),
   .acc_we    (acc_we),
   .acc_q     (acc_q),
   .neg_flag  (neg_flag),
   .zero_flag (zero_flag)
);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
   logic       clk = 1'b0;
   logic       rst;
   logic [2:0] op_sel;
   logic [7:0] bus_in;
   logic       acc_we;
   logic [7:0] acc_q;
   logic       neg_flag;
   logic       zero_flag;

   int total = 0;
   int bad   = 0;
   bit finished = 0;
   int model;

   always #2 clk = ~clk;

   acc_alu dut (
      .clk       (clk),
      .rst       (rst),
      .op_sel    (op_sel),
      .bus_in    (bus_in),
      .acc_we    (acc_we),
      .acc_q     (acc_q),
      .neg_flag  (neg_flag),
      .zero_flag (zero_flag)
   );

   function automatic string tag_for(input bit r, input bit we, input logic [2:0] op);
      if (r) return "R1";
      if (!we) return "R2";
      case (op)
         3'b000: return "R3";
         3'b001: return "R4";
         3'b010: return "R5";
         3'b011: return "R6";
         3'b100: return "R7";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
      end
   endtask

   // one clock: drive at negedge, model the edge, compare at next negedge
   task automatic step(input bit r, input bit we, input logic [2:0] op, input logic [7:0] b);
      string tg;
      tg = tag_for(r, we, op);
      rst = r; acc_we = we; op_sel = op; bus_in = b;
      @(posedge clk);
      if (r) model = 0;
      else if (we) begin
         case (op)
            3'b000: model = (model + b) % 256;
            3'b001: model = model & b;
            3'b010: model = model | b;
            3'b011: model = 255 - model;
            3'b100: model = b;
            default: ;
         endcase
      end
      @(negedge clk);
      check(tg, acc_q, model);
      check("R8", neg_flag, (model >= 128) ? 1 : 0);
      check("R9", zero_flag, (model == 0) ? 1 : 0);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model = 0;
      rst = 1; acc_we = 1; op_sel = 3'b100; bus_in = 8'hFF;
      @(negedge clk);
      step(1, 1, 3'b100, 8'hFF);        // R1 reset wins over write
      step(0, 1, 3'b100, 8'hC8);        // R7 load 200
      step(0, 1, 3'b000, 8'd100);       // R3 200+100 wraps to 44
      step(0, 1, 3'b100, 8'h80);
      step(0, 1, 3'b000, 8'h80);        // R3 wrap to zero, R9 zero set
      step(0, 1, 3'b011, 8'h5A);        // R6 ~0 = FF, bus ignored
      step(0, 1, 3'b011, 8'hFF);        // R6 back to 0
      step(0, 1, 3'b100, 8'hF0);
      step(0, 1, 3'b001, 8'h3C);        // R4 -> 30
      step(0, 1, 3'b010, 8'h81);        // R5 -> B1
      step(0, 0, 3'b100, 8'h00);        // R2 hold despite load code
      step(0, 0, 3'b011, 8'h00);        // R2
      for (int c = 5; c < 8; c++) step(0, 1, 3'(c), 8'h00); // R10 reserved
      step(0, 1, 3'b100, 8'h00);        // R7 load zero, acc ignored
      step(0, 1, 3'b010, 8'h7F);        // R5, R8 clear
      step(1, 0, 3'b000, 8'h11);        // R1 reset without write
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 50) == 0, ($urandom % 4) != 0,
              3'($urandom % 8), 8'($urandom));
      end
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule